// File: doc/BRIEF.md
# Scanned Key Matrix Emulator with Paced Event Queue

This block stands in for a physical key matrix in front of a host that scans it. The host drives eleven column strobe lines and reads seven row sense lines back. Key activity enters as 8-bit scan codes. Bit 7 of a code marks a release and the low seven bits name the key. Codes wait in a 16-entry queue. A free-running divider produces a tick, and on each tick at most one queued code is taken. The code goes through a writable 128-entry table that gives its matrix row and column, and the pressed-key bitmap of that row is updated.

The sense outputs are purely combinational. A row's sense line is high whenever any pressed key of that row sits on a strobe line that is currently high. A change of strobe pattern is therefore visible in the same cycle. A table row one past the last real row is reserved for special keys. These drive five discrete outputs, each with its own inversion control, and never appear on the matrix. A release-all input drops every matrix key at once, as a state restore would.

Top module: `kbd_matrix_emu`

## Requirements
- R1: After reset, sense_o is 0, gpio_o equals gpio_inv_i, overflow_o is 0 and the queue and table are empty. The internal reset is released on the second rising clock edge after rst_n goes high. The third edge is the first one with any effect.
- R2: sense_o[r] is 1 exactly when row r has at least one pressed column c with strobe_i[c] high. It follows strobe_i combinationally.
- R3: The tick fires every TICK_DIV cycles. The first tick falls on the TICK_DIV-th functional edge. Each tick removes and applies at most one queued code.
- R4: A table entry is 8 bits: bit 7 valid, bits 6:4 row, bits 3:0 column. A code with bit 7 clear sets the key's bit and a code with bit 7 set clears it. The lookup index is code bits 6:0.
- R5: A code whose entry is not valid has no effect. So has a matrix entry with column 11 or above.
- R6: An entry with row 7 is a special key. Columns 0 to 4 select gpio_o bit k, which equals the key's pressed state XOR gpio_inv_i[k]. Columns 5 and above are ignored.
- R7: Queued codes are applied in arrival order. The queue holds 16 codes.
- R8: A code that arrives while the queue holds 16 entries is dropped. It sets overflow_o, which stays 1 until reset.
- R9: release_all_i clears every matrix row in that cycle, so sense_o is 0 from the next cycle. Special-key outputs are kept, and no code is taken from the queue in that cycle.
- R10: A table write affects codes applied from the following cycle onward. A code applied in the same cycle as the write uses the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid_i | input | 1 | Scan code present this cycle |
| ev_code_i | input | 8 | Scan code, bit 7 = release |
| map_we_i | input | 1 | Table write enable |
| map_addr_i | input | 7 | Table index (key code) |
| map_wdata_i | input | 8 | Table entry {valid, row[2:0], col[3:0]} |
| strobe_i | input | 11 | Column strobe levels from the host |
| release_all_i | input | 1 | Clear all matrix keys |
| gpio_inv_i | input | 5 | Per-output inversion for special keys |
| sense_o | output | 7 | Row sense levels to the host |
| gpio_o | output | 5 | Special-key outputs |
| overflow_o | output | 1 | Sticky queue overflow flag |

## Verification
The bench builds the block with TICK_DIV set to 8 and keeps the matrix at its default eleven by seven, with five special outputs. The short tick lets a burst of back-to-back codes outrun the drain rate, so the queue fills, drops codes and raises the overflow flag within a few dozen cycles. The whole queue then drains in about 130 cycles. This short period also lets tests land ticks, table writes and release-all pulses in the same cycle as other activity. A behavioural model with its own queue and per-row bitmaps is compared with sense_o, gpio_o and overflow_o in every cycle while the strobe pattern changes.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  // What a looked-up key code does to the key state
  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_MATRIX  = 2'd1,
    ACT_SPECIAL = 2'd2
  } key_act_e;
endpackage

// File: rtl/kbd_tick.sv
module kbd_tick #(
  parameter int TICK_DIV = 1562500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (TICK_DIV > 1) begin : g_pulse_chk
      // R3
      tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/kbd_evq.sv
module kbd_evq #(
  parameter int DEPTH  = 16,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              pop_i,
  output logic [CODE_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [CODE_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign head_o  = mem[rd_q];
  assign ovf_o   = ovf_q;
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  always_comb begin
    wr_d  = push_ok ? wr_q + 1'b1 : wr_q;
    rd_d  = pop_ok  ? rd_q + 1'b1 : rd_q;
    cnt_d = cnt_q;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (!push_ok && pop_ok) cnt_d = cnt_q - 1'b1;
    ovf_d = ovf_q || (push_i && full_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= code_i;
  end

  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o) |=> ovf_o);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  // R7
  push_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !full_o && !pop_i) |=> !empty_o);
endmodule

// File: rtl/kbd_keymap.sv
module kbd_keymap
  import kbd_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int ROW_W     = 3,
  parameter int COL_W     = 4,
  parameter int N_SENSE   = 7,
  parameter int N_STROBE  = 11,
  parameter int N_SPECIAL = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       waddr_i,
  input  logic [ROW_W+COL_W:0]   wdata_i,
  input  logic [IDX_W-1:0]       lk_idx_i,
  output key_act_e               act_o,
  output logic [ROW_W-1:0]       row_o,
  output logic [COL_W-1:0]       col_o
);
  localparam int N_ENT = 1 << IDX_W;
  localparam int DW    = ROW_W + COL_W;
  localparam logic [ROW_W-1:0] SPEC_ROW = ROW_W'(N_SENSE);
  localparam logic [COL_W:0]   STR_LIM  = (COL_W+1)'(N_STROBE);
  localparam logic [COL_W:0]   SPC_LIM  = (COL_W+1)'(N_SPECIAL);

  logic [DW-1:0]    mem [N_ENT];
  logic [N_ENT-1:0] vld_q, vld_d;
  logic [DW-1:0]    ent;

  always_comb begin
    vld_d = vld_q;
    if (we_i) vld_d[waddr_i] = wdata_i[DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i[DW-1:0];
  end

  assign ent   = mem[lk_idx_i];
  assign row_o = ent[COL_W +: ROW_W];
  assign col_o = ent[COL_W-1:0];

  always_comb begin
    act_o = ACT_NONE;
    if (vld_q[lk_idx_i]) begin
      if (row_o == SPEC_ROW) begin
        if ({1'b0, col_o} < SPC_LIM) act_o = ACT_SPECIAL;
      end else if (row_o < SPEC_ROW) begin
        if ({1'b0, col_o} < STR_LIM) act_o = ACT_MATRIX;
      end
    end
  end
endmodule

// File: rtl/kbd_keystate.sv
module kbd_keystate
  import kbd_pkg::*;
#(
  parameter int ROW_W     = 3,
  parameter int COL_W     = 4,
  parameter int N_SENSE   = 7,
  parameter int N_STROBE  = 11,
  parameter int N_SPECIAL = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 apply_i,
  input  key_act_e             act_i,
  input  logic [ROW_W-1:0]     row_i,
  input  logic [COL_W-1:0]     col_i,
  input  logic                 press_i,
  input  logic                 clr_i,
  input  logic [N_STROBE-1:0]  strobe_i,
  input  logic [N_SPECIAL-1:0] gpio_inv_i,
  output logic [N_SENSE-1:0]   sense_o,
  output logic [N_SPECIAL-1:0] gpio_o
);
  logic [N_SENSE-1:0][N_STROBE-1:0] rows_q, rows_d;
  logic [N_SPECIAL-1:0]             spec_q, spec_d;

  always_comb begin
    rows_d = rows_q;
    spec_d = spec_q;
    if (clr_i) begin
      rows_d = '0;
    end else if (apply_i) begin
      for (int r = 0; r < N_SENSE; r++)
        for (int c = 0; c < N_STROBE; c++)
          if (act_i == ACT_MATRIX && row_i == ROW_W'(r) && col_i == COL_W'(c))
            rows_d[r][c] = press_i;
      for (int s = 0; s < N_SPECIAL; s++)
        if (act_i == ACT_SPECIAL && col_i == COL_W'(s))
          spec_d[s] = press_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_q <= '0;
      spec_q <= '0;
    end else begin
      rows_q <= rows_d;
      spec_q <= spec_d;
    end
  end

  generate
    for (genvar g = 0; g < N_SENSE; g++) begin : g_sense
      assign sense_o[g] = |(rows_q[g] & strobe_i);
    end
  endgenerate

  assign gpio_o = spec_q ^ gpio_inv_i;

  // R9
  clear_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sense_o == '0));
  // R9
  clear_keeps_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !apply_i) |=> (!$stable(gpio_inv_i) || $stable(gpio_o)));
  // R2
  idle_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!apply_i && !clr_i) |=> (!$stable(strobe_i) || $stable(sense_o)));
endmodule

// File: rtl/kbd_matrix_emu.sv
module kbd_matrix_emu
  import kbd_pkg::*;
#(
  parameter int N_STROBE   = 11,
  parameter int N_SENSE    = 7,
  parameter int N_SPECIAL  = 5,
  parameter int FIFO_DEPTH = 16,
  parameter int TICK_DIV   = 1562500,
  parameter int CODE_W     = 8,
  localparam int COL_W     = $clog2(N_STROBE),
  localparam int ROW_W     = $clog2(N_SENSE + 1),
  localparam int ENT_W     = ROW_W + COL_W + 1,
  localparam int IDX_W     = CODE_W - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_valid_i,
  input  logic [CODE_W-1:0]    ev_code_i,
  input  logic                 map_we_i,
  input  logic [IDX_W-1:0]     map_addr_i,
  input  logic [ENT_W-1:0]     map_wdata_i,
  input  logic [N_STROBE-1:0]  strobe_i,
  input  logic                 release_all_i,
  input  logic [N_SPECIAL-1:0] gpio_inv_i,
  output logic [N_SENSE-1:0]   sense_o,
  output logic [N_SPECIAL-1:0] gpio_o,
  output logic                 overflow_o
);
  logic              rs_meta_q, rs_q;
  logic              tick, pop, empty, full;
  logic [CODE_W-1:0] head;
  key_act_e          act;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;

  // reset: asserted asynchronously, released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  assign pop = tick && !empty && !release_all_i;

  kbd_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rs_q), .tick_o(tick)
  );

  kbd_evq #(.DEPTH(FIFO_DEPTH), .CODE_W(CODE_W)) u_evq (
    .clk(clk), .rst_n(rs_q), .push_i(ev_valid_i), .code_i(ev_code_i),
    .pop_i(pop), .head_o(head), .empty_o(empty), .full_o(full),
    .ovf_o(overflow_o)
  );

  kbd_keymap #(
    .IDX_W(IDX_W), .ROW_W(ROW_W), .COL_W(COL_W), .N_SENSE(N_SENSE),
    .N_STROBE(N_STROBE), .N_SPECIAL(N_SPECIAL)
  ) u_map (
    .clk(clk), .rst_n(rs_q), .we_i(map_we_i), .waddr_i(map_addr_i),
    .wdata_i(map_wdata_i), .lk_idx_i(head[IDX_W-1:0]),
    .act_o(act), .row_o(row), .col_o(col)
  );

  kbd_keystate #(
    .ROW_W(ROW_W), .COL_W(COL_W), .N_SENSE(N_SENSE),
    .N_STROBE(N_STROBE), .N_SPECIAL(N_SPECIAL)
  ) u_keys (
    .clk(clk), .rst_n(rs_q), .apply_i(pop), .act_i(act), .row_i(row),
    .col_i(col), .press_i(!head[CODE_W-1]), .clr_i(release_all_i),
    .strobe_i(strobe_i), .gpio_inv_i(gpio_inv_i), .sense_o(sense_o),
    .gpio_o(gpio_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rs_q |-> (sense_o == '0 && !overflow_o));
  // R9
  release_no_pop_chk: assert property (@(posedge clk) disable iff (!rs_q)
    (release_all_i && !ev_valid_i && !empty) |=> !empty);
endmodule

// File: tb/kbd_matrix_emu_tb.sv
module kbd_matrix_emu_tb;
  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [7:0]  ev_code = '0;
  logic        map_we = 1'b0;
  logic [6:0]  map_addr = '0;
  logic [7:0]  map_wdata = '0;
  logic [10:0] strobe = '0;
  logic        rel_all = 1'b0;
  logic [4:0]  inv = 5'b10010;
  logic [6:0]  sense;
  logic [4:0]  gpio;
  logic        ovf;

  int nchk = 0, nerr = 0, cyc = 0;
  bit started = 0, done = 0;

  always #2.5 clk = ~clk;

  kbd_matrix_emu #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid_i(ev_valid), .ev_code_i(ev_code),
    .map_we_i(map_we), .map_addr_i(map_addr), .map_wdata_i(map_wdata),
    .strobe_i(strobe), .release_all_i(rel_all), .gpio_inv_i(inv),
    .sense_o(sense), .gpio_o(gpio), .overflow_o(ovf)
  );

  // ---------------- reference model ----------------
  int m_rows [7];
  int m_spec [5];
  int m_map  [128];
  int m_q [$];
  int m_cnt, m_sync;
  bit m_ovf;

  function automatic logic [6:0] m_sense();
    logic [6:0] s;
    for (int r = 0; r < 7; r++) s[r] = ((m_rows[r] & int'(strobe)) != 0);
    return s;
  endfunction

  function automatic logic [4:0] m_gpio();
    logic [4:0] g;
    for (int k = 0; k < 5; k++) g[k] = m_spec[k][0] ^ inv[k];
    return g;
  endfunction

  task automatic m_apply(input int code);
    int e, row, col;
    bit press;
    e = m_map[code & 8'h7f];
    if (e < 0) return;
    row = (e >> 4) & 7;
    col = e & 15;
    press = ((code & 8'h80) == 0);
    if (row < 7 && col < 11) begin
      if (press) m_rows[row] |= (1 << col);
      else       m_rows[row] &= ~(1 << col);
    end else if (row == 7 && col < 5) begin
      m_spec[col] = press;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_rows[i]) m_rows[i] = 0;
      foreach (m_spec[i]) m_spec[i] = 0;
      foreach (m_map[i])  m_map[i] = -1;
      m_q.delete();
      m_cnt = 0; m_sync = 0; m_ovf = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      int  pre;
      bit  tk;
      pre = m_q.size();
      tk  = (m_cnt == DIV - 1);
      if (tk && pre > 0 && !rel_all) m_apply(m_q.pop_front());
      if (rel_all) foreach (m_rows[i]) m_rows[i] = 0;
      if (ev_valid) begin
        if (pre < 16) m_q.push_back(int'(ev_code));
        else          m_ovf = 1;
      end
      if (map_we) m_map[map_addr] = map_wdata[7] ? int'(map_wdata[6:0]) : -1;
      m_cnt = tk ? 0 : m_cnt + 1;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // every-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    cyc++;
    #1;
    if (started && !done) begin
      chk("R2/R3/R4 sense", int'(sense), int'(m_sense()));
      chk("R6 gpio", int'(gpio), int'(m_gpio()));
      chk("R8 overflow", int'(ovf), int'(m_ovf));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    wait (cyc >= 20000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 20000);
      finish_run();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] c);
    @(negedge clk); ev_valid = 1'b1; ev_code = c;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic mapw(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); map_we = 1'b1; map_addr = a; map_wdata = d;
    @(negedge clk); map_we = 1'b0;
  endtask

  task automatic look(input logic [10:0] s);
    @(negedge clk); strobe = s;
    #2;
  endtask

  initial begin
    step(3);
    started = 1;
    #2;
    // R1 reset values
    chk("R1 sense at reset", int'(sense), 0);
    chk("R1 gpio at reset", int'(gpio), int'(5'b10010));
    chk("R1 overflow at reset", int'(ovf), 0);
    rst_n = 1'b1;
    step(3);

    mapw(7'h10, 8'hA1);   // row2 col1
    mapw(7'h1d, 8'h80);   // row0 col0
    mapw(7'h02, 8'h81);   // row0 col1
    mapw(7'h44, 8'hD0);   // row5 col0
    mapw(7'h52, 8'hF0);   // special 0
    mapw(7'h43, 8'hF1);   // special 1
    mapw(7'h30, 8'hF6);   // special col 6: ignored
    mapw(7'h20, 8'hBC);   // row3 col12: ignored

    push(8'h10); step(10);
    look(11'h000); chk("R2 no strobe", int'(sense), 0);
    look(11'h002); chk("R2 row2 col1", int'(sense), int'(7'b0000100));
    look(11'h7fd); chk("R2 other strobes", int'(sense), 0);

    push(8'h1d); push(8'h02); step(20);
    look(11'h001); chk("R4 row0 col0 press", int'(sense), int'(7'b0000001));
    look(11'h002); chk("R4 shared column", int'(sense), int'(7'b0000101));
    push(8'h90); step(10);
    look(11'h002); chk("R4 release clears", int'(sense), int'(7'b0000001));

    push(8'h44); step(10);
    push(8'h7f); step(10);
    look(11'h7ff); chk("R5 unmapped code", int'(sense), int'(7'b0100001));
    push(8'h20); step(10);
    look(11'h7ff); chk("R5 column out of range", int'(sense), int'(7'b0100001));

    push(8'h52); step(10); #2;
    chk("R6 special press", int'(gpio), int'(5'b10011));
    push(8'hc3); step(10); #2;
    chk("R6 release unpressed", int'(gpio), int'(5'b10011));
    push(8'h43); step(10); #2;
    chk("R6 special col1", int'(gpio), int'(5'b10001));
    push(8'h30); step(10); #2;
    chk("R6 special col6 ignored", int'(gpio), int'(5'b10001));
    @(negedge clk); inv = 5'b00000; #2;
    chk("R6 inversion live", int'(gpio), int'(5'b00011));

    mapw(7'h7f, 8'hC2);   // R10 remap to row4 col2
    push(8'h7f); step(10);
    look(11'h004); chk("R10 remapped key", int'(sense), int'(7'b0010000));

    // R7 ordering: press then release of the same key
    push(8'h10); push(8'h90); step(25);
    look(11'h002); chk("R7 order press then release", int'(sense), int'(7'b0000001));

    // R8 burst of 20 codes outruns the drain
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      ev_valid = 1'b1; ev_code = (i % 2 == 0) ? 8'h44 : 8'hc4;
      @(negedge clk);
    end
    ev_valid = 1'b0; #2;
    chk("R8 overflow raised", int'(ovf), 1);
    step(150); #2;
    chk("R8 overflow sticky", int'(ovf), 1);

    // R9 release all
    look(11'h7ff);
    @(negedge clk); rel_all = 1'b1;
    @(negedge clk); rel_all = 1'b0; #2;
    chk("R9 sense cleared", int'(sense), 0);
    chk("R9 special kept", int'(gpio), int'(5'b00011));
    push(8'h1d);
    @(negedge clk); rel_all = 1'b1;
    step(12); rel_all = 1'b0;
    step(12);
    look(11'h001); chk("R9 held code applied later", int'(sense), int'(7'b0000001));

    step(5);
    finish_run();
  end
endmodule